// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a 32-bit virtual address into a physical address when a translation is not already held elsewhere. It assumes 4 KB pages and 4-byte table entries, so each table fills exactly one page and holds 1024 entries. A walk starts from the page number of the root table, supplied with the request. The block fetches the first-level entry, checks it, fetches the second-level entry and checks that one as well. It then either returns the physical address or reports which kind of fault stopped it and at which level.

All table traffic goes over one memory port that carries a single outstanding access. On a successful walk the block updates the bookkeeping bits of the final entry in memory: the accessed flag always, and the modified flag when the request is a store. It writes the entry back only when one of those flags actually changes.

A client presents a request while `req_ready` is high. The block raises `resp_valid` for exactly one cycle with the result. It then becomes ready again.

Top module: `ptw_walker`

## Requirements
- R1: After a synchronous active-low reset the block is idle: `req_ready` is 1, `resp_valid` is 0 and `mem_req` is 0.
- R2: A request is taken only on a cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low from the cycle after acceptance until the response cycle has passed.
- R3: The first memory access is a read at `{table_ppn, vaddr[31:22], 2'b00}`.
- R4: The second memory access is a read at `{first_entry[31:12], vaddr[21:12], 2'b00}`.
- R5: When no fault occurs, the response has `resp_fault` = 2'b00 and `resp_paddr` = `{second_entry[31:12], vaddr[11:0]}`.
- R6: Entry bit 0 is the present flag. If it is 0, the walk ends with `resp_fault` = 2'b01 and `resp_level` giving the level (0 = first, 1 = second). A first-level absence issues no second read. Absence is reported in preference to a permission failure in the same entry.
- R7: Entry bit 1 grants writing and entry bit 2 grants user access. A store needs bit 1 set in both entries, and a user request needs bit 2 set in both entries. A denial ends the walk with `resp_fault` = 2'b10, and `resp_level` names the first entry that denied it.
- R8: On success the new second-level entry is the old one with bit 5 (accessed) set, and with bit 6 (modified) set for a store. All other bits are kept. The entry is written to the address of the second read, and only when the new value differs from the old one.
- R9: A walk that faults writes nothing to memory. First-level entries are never written.
- R10: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold their values.
- R11: `resp_valid` is high for exactly one cycle per accepted request. On a fault, `resp_paddr` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Request is a store |
| req_user | input | 1 | Request comes from user mode |
| table_ppn | input | 20 | Page number of the first-level table |
| mem_req | output | 1 | Memory access requested |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Entry value to write |
| mem_ack | input | 1 | Memory access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| resp_valid | output | 1 | Result present, one cycle |
| resp_paddr | output | 32 | Physical address, 0 on a fault |
| resp_fault | output | 2 | 00 none, 01 not present, 10 protection |
| resp_level | output | 1 | Level that faulted: 0 first, 1 second |

## Verification
The hardest cases to reach from the ports depend on particular bit patterns in memory. One is a store that succeeds against a final entry whose accessed and modified flags are both already set, so no write-back may occur. Another is an entry that is absent and also denies permission, where the absence must win. Random walks over a small pre-filled set of tables rarely line these up. The bench therefore writes specific entry values into its memory model just before directed walks. Random walks with random memory latency then cover the mix of faults and write-backs, and a bench function recomputes each result from the memory contents at the time of issue.

// File: rtl/ptw_pkg.sv
// Package: shared widths, entry bit positions, walk states and fault codes
// for the page table walker. Assumes 32-bit addresses, 4 KB pages and
// 4-byte entries.
package ptw_pkg;
    localparam int unsigned VA_W   = 32;
    localparam int unsigned OFF_W  = 12;
    localparam int unsigned PTE_W  = 32;
    localparam int unsigned ENT_B  = 2;                      // log2 of entry bytes
    localparam int unsigned IDX_W  = OFF_W - ENT_B;          // entries per table index
    localparam int unsigned PPN_W  = VA_W - OFF_W;
    localparam int unsigned PERM_W = 3;
    localparam int unsigned LEVELS = 2;

    localparam int unsigned BIT_PRESENT = 0;
    localparam int unsigned BIT_WRITE   = 1;
    localparam int unsigned BIT_USER    = 2;
    localparam int unsigned BIT_ACCESS  = 5;
    localparam int unsigned BIT_MODIFY  = 6;

    typedef enum logic [2:0] {
        ST_IDLE, ST_READ_L1, ST_CHECK_L1, ST_READ_L2,
        ST_CHECK_L2, ST_WRITEBACK, ST_DONE
    } walk_state_e;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'b00,
        FLT_ABSENT = 2'b01,
        FLT_PROT   = 2'b10
    } fault_kind_e;
endpackage

// File: rtl/ptw_perm_check.sv
// Module: judges one table entry against a request. Reports absence ahead
// of any permission failure. Assumes the caller applies it to each level
// in turn, so that together the levels form a combined check.
module ptw_perm_check
    import ptw_pkg::*;
(
    input  logic [PERM_W-1:0] perm,
    input  logic              is_write,
    input  logic              is_user,
    output logic [1:0]        kind
);
    // Classify the entry: absent first, then store and user rights.
    always_comb begin
        if (!perm[BIT_PRESENT])
            kind = FLT_ABSENT;
        else if ((is_write && !perm[BIT_WRITE]) || (is_user && !perm[BIT_USER]))
            kind = FLT_PROT;
        else
            kind = FLT_NONE;
    end
endmodule

// File: rtl/ptw_addr_gen.sv
// Module: forms the byte addresses of the two entries from the root page
// number, the virtual address and the first-level entry's page number.
// Assumes tables are page aligned.
module ptw_addr_gen
    import ptw_pkg::*;
(
    input  logic [PPN_W-1:0] root_ppn,
    input  logic [VA_W-1:0]  vaddr,
    input  logic [PPN_W-1:0] l1_ppn,
    output logic [VA_W-1:0]  l1_addr,
    output logic [VA_W-1:0]  l2_addr
);
    localparam int unsigned HI_LSB = OFF_W + IDX_W;

    // Concatenate table page, index field and zero entry-byte bits.
    always_comb begin
        l1_addr = {root_ppn, vaddr[VA_W-1:HI_LSB], {ENT_B{1'b0}}};
        l2_addr = {l1_ppn, vaddr[HI_LSB-1:OFF_W], {ENT_B{1'b0}}};
    end
endmodule

// File: rtl/ptw_fsm.sv
// Module: sequences a walk through read, check and write-back steps over a
// single-outstanding memory port. Assumes memory holds each request until
// it acknowledges, and that fault kinds arrive from per-level checkers.
module ptw_fsm
    import ptw_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    output logic                         req_ready,
    input  logic [VA_W-1:0]              req_vaddr,
    input  logic                         req_write,
    input  logic                         req_user,
    input  logic [PPN_W-1:0]             table_ppn,
    output logic                         mem_req,
    output logic                         mem_we,
    output logic [VA_W-1:0]              mem_addr,
    output logic [PTE_W-1:0]             mem_wdata,
    input  logic                         mem_ack,
    input  logic [PTE_W-1:0]             mem_rdata,
    output logic                         resp_valid,
    output logic [VA_W-1:0]              resp_paddr,
    output logic [1:0]                   resp_fault,
    output logic                         resp_level,
    input  logic [VA_W-1:0]              l1_addr,
    input  logic [VA_W-1:0]              l2_addr,
    output logic [PPN_W-1:0]             root_q,
    output logic [VA_W-1:0]              va_q,
    output logic [PPN_W-1:0]             l1_ppn_q,
    output logic [LEVELS-1:0][PERM_W-1:0] lvl_perm,
    output logic                         wr_q,
    output logic                         user_q,
    input  logic [LEVELS-1:0][1:0]       lvl_kind
);
    walk_state_e      state;
    logic [PERM_W-1:0] l1_perm_q;
    logic [PTE_W-1:0]  l2_q;
    logic [PTE_W-1:0]  l2_new_q;
    logic [1:0]        fault_q;
    logic              level_q;
    logic [VA_W-1:0]   paddr_q;
    logic [PTE_W-1:0]  l2_upd;

    // Expose captured permissions to the per-level checkers.
    always_comb begin
        lvl_perm[0] = l1_perm_q;
        lvl_perm[1] = l2_q[PERM_W-1:0];
    end

    // Updated final entry: accessed always, modified on a store.
    always_comb begin
        l2_upd = l2_q;
        l2_upd[BIT_ACCESS] = 1'b1;
        if (wr_q)
            l2_upd[BIT_MODIFY] = 1'b1;
    end

    // Walk sequencer and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            root_q    <= '0;
            va_q      <= '0;
            wr_q      <= 1'b0;
            user_q    <= 1'b0;
            l1_ppn_q  <= '0;
            l1_perm_q <= '0;
            l2_q      <= '0;
            l2_new_q  <= '0;
            fault_q   <= FLT_NONE;
            level_q   <= 1'b0;
            paddr_q   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        root_q  <= table_ppn;
                        va_q    <= req_vaddr;
                        wr_q    <= req_write;
                        user_q  <= req_user;
                        fault_q <= FLT_NONE;
                        level_q <= 1'b0;
                        paddr_q <= '0;
                        state   <= ST_READ_L1;
                    end
                end
                ST_READ_L1: begin
                    if (mem_ack) begin
                        l1_ppn_q  <= mem_rdata[PTE_W-1:OFF_W];
                        l1_perm_q <= mem_rdata[PERM_W-1:0];
                        state     <= ST_CHECK_L1;
                    end
                end
                ST_CHECK_L1: begin
                    if (lvl_kind[0] != FLT_NONE) begin
                        fault_q <= lvl_kind[0];
                        level_q <= 1'b0;
                        state   <= ST_DONE;
                    end else begin
                        state   <= ST_READ_L2;
                    end
                end
                ST_READ_L2: begin
                    if (mem_ack) begin
                        l2_q  <= mem_rdata;
                        state <= ST_CHECK_L2;
                    end
                end
                ST_CHECK_L2: begin
                    if (lvl_kind[1] != FLT_NONE) begin
                        fault_q <= lvl_kind[1];
                        level_q <= 1'b1;
                        state   <= ST_DONE;
                    end else begin
                        paddr_q  <= {l2_q[PTE_W-1:OFF_W], va_q[OFF_W-1:0]};
                        l2_new_q <= l2_upd;
                        state    <= (l2_upd != l2_q) ? ST_WRITEBACK : ST_DONE;
                    end
                end
                ST_WRITEBACK: begin
                    if (mem_ack)
                        state <= ST_DONE;
                end
                ST_DONE:  state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Port outputs decoded from the current state.
    always_comb begin
        req_ready  = (state == ST_IDLE);
        mem_req    = (state == ST_READ_L1) || (state == ST_READ_L2) ||
                     (state == ST_WRITEBACK);
        mem_we     = (state == ST_WRITEBACK);
        mem_addr   = (state == ST_READ_L1) ? l1_addr : l2_addr;
        mem_wdata  = (state == ST_WRITEBACK) ? l2_new_q : '0;
        resp_valid = (state == ST_DONE);
        resp_paddr = paddr_q;
        resp_fault = fault_q;
        resp_level = level_q;
    end

    // R10: a pending access keeps its attributes until acknowledged.
    a_r10_hold_access: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wdata)));

    // R11: a response lasts one cycle and the block is ready after it.
    a_r11_resp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> (!resp_valid && req_ready));

    // R2: once a request is taken the block is busy.
    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R8: every write-back carries the accessed flag.
    a_r8_wb_access: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> mem_wdata[BIT_ACCESS]);

    // R6: an absent first-level entry ends the walk with an absence fault.
    a_r6_l1_absent: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CHECK_L1 && !l1_perm_q[BIT_PRESENT]) |=>
        (resp_valid && resp_fault == FLT_ABSENT && !resp_level));

    // R9: a faulting second-level check never leads to a memory write.
    a_r9_no_wb_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CHECK_L2 && lvl_kind[1] != FLT_NONE) |=> !mem_we);

    // R11: a faulted response carries no address.
    a_r11_fault_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_fault != FLT_NONE) |-> (resp_paddr == '0));
endmodule

// File: rtl/ptw_walker.sv
// Module: top of the two-level page table walker. Wires the sequencer to
// the address former and one entry checker per level. Assumes the root
// table page number is stable for the duration of the request cycle.
module ptw_walker
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [31:0]       req_vaddr,
    input  logic              req_write,
    input  logic              req_user,
    input  logic [19:0]       table_ppn,
    output logic              mem_req,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              resp_valid,
    output logic [31:0]       resp_paddr,
    output logic [1:0]        resp_fault,
    output logic              resp_level
);
    logic [VA_W-1:0]               l1_addr;
    logic [VA_W-1:0]               l2_addr;
    logic [PPN_W-1:0]              root_q;
    logic [VA_W-1:0]               va_q;
    logic [PPN_W-1:0]              l1_ppn_q;
    logic [LEVELS-1:0][PERM_W-1:0] lvl_perm;
    logic [LEVELS-1:0][1:0]        lvl_kind;
    logic                          wr_q;
    logic                          user_q;

    ptw_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_vaddr  (req_vaddr),
        .req_write  (req_write),
        .req_user   (req_user),
        .table_ppn  (table_ppn),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .resp_valid (resp_valid),
        .resp_paddr (resp_paddr),
        .resp_fault (resp_fault),
        .resp_level (resp_level),
        .l1_addr    (l1_addr),
        .l2_addr    (l2_addr),
        .root_q     (root_q),
        .va_q       (va_q),
        .l1_ppn_q   (l1_ppn_q),
        .lvl_perm   (lvl_perm),
        .wr_q       (wr_q),
        .user_q     (user_q),
        .lvl_kind   (lvl_kind)
    );

    ptw_addr_gen u_addr (
        .root_ppn (root_q),
        .vaddr    (va_q),
        .l1_ppn   (l1_ppn_q),
        .l1_addr  (l1_addr),
        .l2_addr  (l2_addr)
    );

    // One entry checker per table level.
    for (genvar lv = 0; lv < LEVELS; lv++) begin : g_level
        ptw_perm_check u_chk (
            .perm     (lvl_perm[lv]),
            .is_write (wr_q),
            .is_user  (user_q),
            .kind     (lvl_kind[lv])
        );
    end
endmodule

// File: tb/ptw_walker_tb_top.sv
// Bench: memory model with random latency, directed corner walks and
// random walks, each compared with a reference computed from memory.
module ptw_walker_tb_top;
    localparam logic [19:0] ROOT = 20'h00003;
    localparam int          MEMW = 4096;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_ready, req_write, req_user;
    logic [31:0] req_vaddr;
    logic [19:0] table_ppn;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        resp_valid, resp_level;
    logic [31:0] resp_paddr;
    logic [1:0]  resp_fault;

    logic [31:0] mem [0:MEMW-1];
    int          checks = 0;
    int          failures = 0;
    int          rd_count, wr_count, delay_cnt;
    logic [31:0] rd_log [0:3];
    logic [31:0] wr_addr_log;
    bit          done_flag = 0;

    always #2 clk = ~clk;

    ptw_walker dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_write(req_write), .req_user(req_user),
        .table_ppn(table_ppn), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .resp_valid(resp_valid), .resp_paddr(resp_paddr),
        .resp_fault(resp_fault), .resp_level(resp_level)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // Memory model: serves one access at a time after 0..2 idle cycles.
    initial begin
        mem_ack = 0; mem_rdata = 0; delay_cnt = 0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 0;
            end else if (mem_req) begin
                if (delay_cnt == 0) begin
                    if (mem_we) begin
                        mem[mem_addr[13:2]] = mem_wdata;
                        wr_addr_log = mem_addr;
                        wr_count++;
                    end else begin
                        mem_rdata = mem[mem_addr[13:2]];
                        if (rd_count < 4) rd_log[rd_count] = mem_addr;
                        rd_count++;
                    end
                    mem_ack = 1;
                    delay_cnt = $urandom % 3;
                end else begin
                    delay_cnt--;
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            failures++;
            $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd1, 32'd0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // One walk with reference model and port-level checks.
    task automatic walk(input logic [31:0] va, input bit wr, input bit usr);
        logic [31:0] a1, a2, e1, e2, enew, exp_pa;
        logic [1:0]  exp_f;
        logic        exp_lv;
        int          exp_rd, exp_wr, wait_cyc;
        a1 = {ROOT, va[31:22], 2'b00};
        e1 = mem[a1[13:2]];
        a2 = {e1[31:12], va[21:12], 2'b00};
        e2 = mem[a2[13:2]];
        enew = e2 | 32'h20 | (wr ? 32'h40 : 32'h0);
        exp_pa = 0; exp_lv = 0; exp_rd = 2; exp_wr = 0;
        if (!e1[0])                          begin exp_f = 2'b01; exp_rd = 1; end
        else if ((wr && !e1[1]) || (usr && !e1[2])) begin exp_f = 2'b10; exp_rd = 1; end
        else if (!e2[0])                     begin exp_f = 2'b01; exp_lv = 1; end
        else if ((wr && !e2[1]) || (usr && !e2[2])) begin exp_f = 2'b10; exp_lv = 1; end
        else begin
            exp_f = 2'b00;
            exp_pa = {e2[31:12], va[11:0]};
            exp_wr = (enew != e2) ? 1 : 0;
        end
        rd_count = 0; wr_count = 0;
        @(negedge clk);
        req_valid = 1; req_vaddr = va; req_write = wr; req_user = usr;
        @(negedge clk);
        req_valid = 0; req_vaddr = $urandom;
        chk("R2 busy after accept", {31'd0, req_ready}, 32'd0);
        wait_cyc = 0;
        while (!resp_valid && wait_cyc < 100) begin
            @(negedge clk);
            wait_cyc++;
        end
        chk("R11 response seen", {31'd0, resp_valid}, 32'd1);
        chk("R5 R6 R7 fault code", {30'd0, resp_fault}, {30'd0, exp_f});
        if (exp_f != 2'b00)
            chk("R6 R7 fault level", {31'd0, resp_level}, {31'd0, exp_lv});
        chk("R5 R11 physical address", resp_paddr, exp_pa);
        @(negedge clk);
        chk("R11 single pulse", {31'd0, resp_valid}, 32'd0);
        chk("R2 ready after response", {31'd0, req_ready}, 32'd1);
        chk("R6 read count", rd_count, exp_rd);
        chk("R3 first read address", rd_log[0], a1);
        if (exp_rd == 2)
            chk("R4 second read address", rd_log[1], a2);
        chk("R8 R9 write count", wr_count, exp_wr);
        chk("R9 first entry untouched", mem[a1[13:2]], e1);
        if (exp_wr == 1) begin
            chk("R8 write-back address", wr_addr_log, a2);
            chk("R8 write-back value", mem[a2[13:2]], enew);
        end else if (exp_rd == 2) begin
            chk("R8 R9 final entry unchanged", mem[a2[13:2]], e2);
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        rst_n = 0; req_valid = 0; req_vaddr = 0; req_write = 0; req_user = 0;
        table_ppn = ROOT; rd_count = 0; wr_count = 0;
        for (int i = 0; i < MEMW; i++) mem[i] = $urandom;
        // First-level table at page 3: entries 0..7 point at pages 0..2.
        for (int i = 0; i < 1024; i++) mem[3072 + i] = 32'h0;
        for (int i = 0; i < 8; i++) begin
            logic [31:0] e;
            e = $urandom & 32'h0000_0FF8;
            e[31:12] = 20'($urandom % 3);
            e[0] = ($urandom % 5) != 0;
            e[1] = ($urandom % 4) != 0;
            e[2] = ($urandom % 4) != 0;
            mem[3072 + i] = e;
        end
        for (int i = 0; i < 3072; i++) begin
            mem[i][0] = ($urandom % 5) != 0;
            mem[i][1] = ($urandom % 3) != 0;
            mem[i][2] = ($urandom % 3) != 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state.
        chk("R1 ready", {31'd0, req_ready}, 32'd1);
        chk("R1 no response", {31'd0, resp_valid}, 32'd0);
        chk("R1 no memory request", {31'd0, mem_req}, 32'd0);

        // R6 absent first level.
        mem[3072 + 10] = 32'h0;
        walk({10'd10, 10'd3, 12'h123}, 0, 0);
        // R6 absent wins over denied rights at the same level.
        mem[3072 + 13] = 32'h0000_2000;
        walk({10'd13, 10'd4, 12'h456}, 1, 1);
        // R7 user request against supervisor-only first level.
        mem[3072 + 12] = 32'h0000_1003;
        mem[1024 + 2]  = 32'h0000_5067;
        walk({10'd12, 10'd2, 12'h001}, 0, 1);
        // Second-level cases through first-level entry 11 (page 1, all rights).
        mem[3072 + 11] = 32'h0000_1007;
        mem[1024 + 5]  = 32'hFFFF_F006;
        walk({10'd11, 10'd5, 12'hABC}, 0, 0);            // R6 absent second level
        mem[1024 + 6]  = 32'hABCD_E065;
        walk({10'd11, 10'd6, 12'h777}, 1, 0);            // R7 store to read-only page
        mem[1024 + 7]  = 32'h1234_5067;
        walk({10'd11, 10'd7, 12'hFFF}, 1, 1);            // R8 flags already set: no write
        mem[1024 + 8]  = 32'h5432_1007;
        walk({10'd11, 10'd8, 12'h000}, 0, 0);            // R8 read sets accessed only
        mem[1024 + 9]  = 32'h1111_1027;
        walk({10'd11, 10'd9, 12'h3A5}, 1, 0);            // R8 store sets modified
        // Random walks over first-level indices 0..11.
        for (int n = 0; n < 300; n++) begin
            logic [31:0] va;
            va = $urandom;
            va[31:22] = 10'($urandom % 12);
            walk(va, 1'($urandom % 2), 1'($urandom % 2));
        end
        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule